// File: doc/BRIEF.md
# LPC Sideband Pin Watcher with Sticky Error Flags

This block sits in a peripheral controller that answers to a host over an LPC bus. It watches three sideband pins from the host: the gate-A20 level, the active-low bus reset and the active-low power-down request. Local firmware sees them through one 8-bit status register. Each pin passes through a two-flop synchroniser. The block detects falling edges on the reset and power-down pins and records each one in a sticky flag.

A flag clears only through a handshake. Firmware must first read the register and see the flag as 1, then write 0 to that bit. Writing 1 never sets a flag. The power-down flag also clears itself while the host holds the bus in reset, and on a pulse from the LPC software-reset logic. While either flag is set, the block holds an error interrupt line high.

Top module: `lpc_sideband_flags`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `rd_data[6:0]` reads 0 and `err_irq` is 0.
- R2: `rd_data[7]` shows the level of `gate_a20_pin` with two clocks of synchronisation delay. This bit is never reset and is not affected by any register write.
- R3: `rd_data[6]` is the host-reset flag. It becomes 1 on the third rising clock edge after a high-to-low change of `host_rst_n_pin` has been sampled.
- R4: The host-reset flag clears only on a write whose `wr_data[6]` is 0, and only if an earlier `rd_stb` cycle returned the flag as 1. A write of 0 without that read leaves the flag at 1.
- R5: `rd_data[5]` is the power-down flag. It sets with the same timing as R3 on a high-to-low change of `host_pd_n_pin`.
- R6: The power-down flag clears when any of these holds: the synchronised `host_rst_n_pin` is low, `lpc_sw_reset` is pulsed, or firmware writes `wr_data[5]`=0 after reading the flag as 1.
- R7: Writes never set a flag. `rd_data[4:0]` always reads 0.
- R8: `err_irq` is high exactly when `rd_data[6]` or `rd_data[5]` is 1.
- R9: When a set event and a clear meet in the same cycle, the set wins. Any write of 0 to a flag bit cancels its earlier read-as-1, so a new read is needed before the next clear.
- R10: A high `hw_standby` at a clock edge clears both flags and both read-as-1 records at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_standby | input | 1 | Synchronous clear of the flags during hardware standby |
| gate_a20_pin | input | 1 | Raw gate-A20 pin level |
| host_rst_n_pin | input | 1 | Raw active-low LPC bus reset pin |
| host_pd_n_pin | input | 1 | Raw active-low LPC power-down pin |
| lpc_sw_reset | input | 1 | One-cycle LPC software-reset pulse |
| rd_stb | input | 1 | Local register read strobe |
| wr_stb | input | 1 | Local register write strobe |
| wr_data | input | 8 | Local write data |
| rd_data | output | 8 | Register view: A20 level, two flags, reserved zeros |
| err_irq | output | 1 | Level error interrupt |

## Verification
The hardest case is a set-wins collision. The flag is already 1 and has been read, and the armed clear write lands on the exact edge where a new falling edge arrives through the synchroniser. The stimulus lowers the reset pin on one falling clock edge. It then places the write strobe two falling edges later, so both events land on the same rising edge. Next comes a second write of 0 with no read in between, to show the earlier read was cancelled. A cycle-accurate model checks every clock, so any single-cycle slip in the synchroniser depth appears as a mismatch.

// File: rtl/lpcsf_pkg.sv
package lpcsf_pkg;

    localparam int REG_W     = 8;
    localparam int A20_BIT   = 7;
    localparam int HRST_BIT  = 6;
    localparam int HPD_BIT   = 5;
    localparam int NUM_PINS  = 3;
    localparam int NUM_FLAGS = 2;

    typedef enum int {
        PIN_A20  = 0,
        PIN_HRST = 1,
        PIN_HPD  = 2
    } pin_idx_e;

    typedef enum int {
        FLG_HPD  = 0,
        FLG_HRST = 1
    } flag_idx_e;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

endpackage

// File: rtl/lpcsf_pin_sync.sv
module lpcsf_pin_sync #(
    parameter int STAGES     = 2,
    parameter bit RESETTABLE = 1'b1,
    parameter bit RESET_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;
    logic          prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], pin};
        prev_d  = chain_q[LAST];
    end

    generate
        if (RESETTABLE) begin : g_rst_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_LVL}};
                else        chain_q <= chain_d;
            end
        end else begin : g_free_chain
            always_ff @(posedge clk) begin
                chain_q <= chain_d;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_LVL;
        else        prev_q <= prev_d;
    end

    assign level = chain_q[LAST];
    assign fall  = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/lpcsf_sticky_flag.sv
module lpcsf_sticky_flag
    import lpcsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_evt,
    input  logic hw_clr,
    input  logic wr_zero,
    input  logic rd_seen,
    output logic flag
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // arming: a read that returned 1 arms; a write of 0 always disarms
        if (wr_zero)
            st_d.armed = 1'b0;
        else if (rd_seen && st_q.flag)
            st_d.armed = 1'b1;
        // flag: clear sources first, then a set event overrides them
        if (hw_clr || (wr_zero && st_q.armed))
            st_d.flag = 1'b0;
        if (set_evt)
            st_d.flag = 1'b1;
        if (!st_d.flag)
            st_d.armed = 1'b0;
        if (standby)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/lpc_sideband_flags.sv
module lpc_sideband_flags
    import lpcsf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_standby,
    input  logic             gate_a20_pin,
    input  logic             host_rst_n_pin,
    input  logic             host_pd_n_pin,
    input  logic             lpc_sw_reset,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             err_irq
);

    localparam int RSVD_W = HPD_BIT;

    logic [NUM_PINS-1:0]  pin_raw;
    logic [NUM_PINS-1:0]  pin_level;
    logic [NUM_PINS-1:0]  pin_fall;
    logic [NUM_FLAGS-1:0] flg_set, flg_hwclr, flg_wr0, flg_q;
    logic                 hrst_fall, hrst_level, hpd_fall;

    assign pin_raw[PIN_A20]  = gate_a20_pin;
    assign pin_raw[PIN_HRST] = host_rst_n_pin;
    assign pin_raw[PIN_HPD]  = host_pd_n_pin;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            lpcsf_pin_sync #(
                .STAGES    (SYNC_STAGES),
                .RESETTABLE(p != PIN_A20),
                .RESET_LVL (1'b1)
            ) i_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (pin_raw[p]),
                .level(pin_level[p]),
                .fall (pin_fall[p])
            );
        end
    endgenerate

    assign hrst_fall  = pin_fall[PIN_HRST];
    assign hrst_level = pin_level[PIN_HRST];
    assign hpd_fall   = pin_fall[PIN_HPD];

    assign flg_set[FLG_HRST]   = hrst_fall;
    assign flg_set[FLG_HPD]    = hpd_fall;
    assign flg_hwclr[FLG_HRST] = 1'b0;
    assign flg_hwclr[FLG_HPD]  = ~hrst_level | lpc_sw_reset;
    assign flg_wr0[FLG_HRST]   = wr_stb & ~wr_data[HRST_BIT];
    assign flg_wr0[FLG_HPD]    = wr_stb & ~wr_data[HPD_BIT];

    generate
        for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
            lpcsf_sticky_flag i_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .standby(hw_standby),
                .set_evt(flg_set[f]),
                .hw_clr (flg_hwclr[f]),
                .wr_zero(flg_wr0[f]),
                .rd_seen(rd_stb),
                .flag   (flg_q[f])
            );
        end
    endgenerate

    assign rd_data = {pin_level[PIN_A20], flg_q[FLG_HRST], flg_q[FLG_HPD], {RSVD_W{1'b0}}};
    assign err_irq = |flg_q;

endmodule

// File: rtl/lpcsf_chk.sv
module lpcsf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_standby,
    input logic       lpc_sw_reset,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       err_irq,
    input logic       hrst_fall,
    input logic       hrst_level,
    input logic       hpd_fall
);

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (rd_data[6] | rd_data[5]));

    // R3
    hrst_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[6]) |-> $past(hrst_fall));

    // R4
    hrst_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[6]) |-> $past(hw_standby || (wr_stb && !wr_data[6])));

    // R6
    hpd_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[5]) |-> $past(hw_standby || lpc_sw_reset || !hrst_level
                                    || (wr_stb && !wr_data[5])));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hrst_fall && !hw_standby) |=> rd_data[6]);

    // R5
    hpd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_fall && !hw_standby) |=> rd_data[5]);

    // R10
    standby_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> (rd_data[6:5] == 2'b00));

endmodule

bind lpc_sideband_flags lpcsf_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_standby  (hw_standby),
    .lpc_sw_reset(lpc_sw_reset),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .err_irq     (err_irq),
    .hrst_fall   (hrst_fall),
    .hrst_level  (hrst_level),
    .hpd_fall    (hpd_fall)
);

// File: tb/test_lpc_sideband_flags.sv
`timescale 1ns/1ps
module test_lpc_sideband_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_standby = 1'b0;
    logic       gate_a20_pin = 1'b0;
    logic       host_rst_n_pin = 1'b1;
    logic       host_pd_n_pin = 1'b1;
    logic       lpc_sw_reset = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpc_sideband_flags i_lpc_sideband_flags (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby),
        .gate_a20_pin(gate_a20_pin), .host_rst_n_pin(host_rst_n_pin),
        .host_pd_n_pin(host_pd_n_pin), .lpc_sw_reset(lpc_sw_reset),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd_data), .err_irq(err_irq)
    );

    // ---------------- reference model ----------------
    bit hr_h[$];
    bit pd_h[$];
    bit a20_h[$];
    bit m_hr, m_pd, a_hr, a_pd;

    task automatic upd(input bit of, input bit oa, input bit set, input bit hw,
                       input bit w0, input bit rd, input bit sb,
                       output bit nf, output bit na);
        if (sb)                  nf = 0;
        else if (set)            nf = 1;
        else if (hw || (w0 && oa)) nf = 0;
        else                     nf = of;
        if (sb || !nf)           na = 0;
        else if (w0)             na = 0;
        else if (rd && of)       na = 1;
        else                     na = oa;
    endtask

    initial begin
        hr_h = '{1, 1, 1};
        pd_h = '{1, 1, 1};
    end

    always @(posedge clk) begin
        bit f_hr, f_pd, hw, nf, na;
        if (!rst_n) begin
            hr_h = '{1, 1, 1};
            pd_h = '{1, 1, 1};
            m_hr = 0; m_pd = 0; a_hr = 0; a_pd = 0;
        end else begin
            f_hr = hr_h[2] && !hr_h[1];
            f_pd = pd_h[2] && !pd_h[1];
            hw   = !hr_h[1] || lpc_sw_reset;
            upd(m_hr, a_hr, f_hr, 1'b0, wr_stb && !wr_data[6], rd_stb, hw_standby, nf, na);
            m_hr = nf; a_hr = na;
            upd(m_pd, a_pd, f_pd, hw, wr_stb && !wr_data[5], rd_stb, hw_standby, nf, na);
            m_pd = nf; a_pd = na;
            hr_h.push_front(host_rst_n_pin); void'(hr_h.pop_back());
            pd_h.push_front(host_pd_n_pin);  void'(pd_h.pop_back());
        end
        a20_h.push_front(gate_a20_pin);
        if (a20_h.size() > 3) void'(a20_h.pop_back());
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data[6] == m_hr, "R3/R4 host-reset flag", rd_data[6], m_hr);
            check(rd_data[5] == m_pd, "R5/R6 power-down flag", rd_data[5], m_pd);
            check(rd_data[4:0] == 5'd0, "R7 reserved bits", rd_data[4:0], 0);
            check(err_irq == (m_hr | m_pd), "R8 interrupt", err_irq, m_hr | m_pd);
            if (a20_h.size() >= 3)
                check(rd_data[7] == a20_h[1], "R2 a20 monitor", rd_data[7], a20_h[1]);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1; step(1); rd_stb = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_stb = 1; wr_data = d; step(1); wr_stb = 0; wr_data = 8'h00;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        step(1);
        // R1: during reset
        check(rd_data[6:0] == 7'd0 && !err_irq, "R1 in reset", rd_data, 0);
        step(3);
        rst_n = 1;
        step(1);
        check(rd_data[6:0] == 7'd0 && !err_irq, "R1 after release", rd_data, 0);

        // R2: a20 level with two-clock delay
        gate_a20_pin = 1; step(1);
        check(rd_data[7] == 1'b0, "R2 not yet", rd_data[7], 0);
        step(1);
        check(rd_data[7] == 1'b1, "R2 level shown", rd_data[7], 1);
        do_write(8'h00);
        check(rd_data[7] == 1'b1, "R2 write ignored", rd_data[7], 1);

        // R3: host reset falling edge, set on third edge
        host_rst_n_pin = 0; step(2);
        check(rd_data[6] == 1'b0, "R3 latency", rd_data[6], 0);
        step(1);
        check(rd_data[6] == 1'b1, "R3 set", rd_data[6], 1);
        check(err_irq == 1'b1, "R8 irq high", err_irq, 1);
        host_rst_n_pin = 1; step(3);

        // R4: write 0 without read
        do_write(8'h00); step(1);
        check(rd_data[6] == 1'b1, "R4 no clear unread", rd_data[6], 1);
        do_read(); do_write(8'h00); step(1);
        check(rd_data[6] == 1'b0, "R4 cleared", rd_data[6], 0);
        check(err_irq == 1'b0, "R8 irq low", err_irq, 0);

        // R5 / R6 software reset
        host_pd_n_pin = 0; step(3);
        check(rd_data[5] == 1'b1, "R5 set", rd_data[5], 1);
        lpc_sw_reset = 1; step(1); lpc_sw_reset = 0;
        check(rd_data[5] == 1'b0, "R6 sw reset clear", rd_data[5], 0);
        host_pd_n_pin = 1; step(3);

        // R6 firmware clear
        host_pd_n_pin = 0; step(3);
        do_read(); do_write(8'hDF); step(1);
        check(rd_data[5] == 1'b0, "R6 firmware clear", rd_data[5], 0);
        host_pd_n_pin = 1; step(3);

        // R6 host reset level clears power-down flag, sets host-reset flag
        host_pd_n_pin = 0; step(4);
        host_rst_n_pin = 0; step(4);
        check(rd_data[6:5] == 2'b10, "R6 hw reset clears pd", rd_data[6:5], 2);
        host_rst_n_pin = 1; host_pd_n_pin = 1; step(4);

        // R7: writing ones never sets
        do_read(); do_write(8'h00); step(1);
        do_write(8'hFF); step(1);
        check(rd_data[6:0] == 7'd0, "R7 write ones", rd_data[6:0], 0);

        // R9: set wins over armed clear
        host_rst_n_pin = 0; step(3); host_rst_n_pin = 1; step(3);
        do_read();
        host_rst_n_pin = 0;
        step(2);
        do_write(8'h00);
        check(rd_data[6] == 1'b1, "R9 set wins", rd_data[6], 1);
        host_rst_n_pin = 1; step(3);
        do_write(8'h00); step(1);
        check(rd_data[6] == 1'b1, "R9 disarmed", rd_data[6], 1);
        do_read(); do_write(8'h00); step(1);
        check(rd_data[6] == 1'b0, "R9 rearmed clear", rd_data[6], 0);

        // R10: standby clears
        host_rst_n_pin = 0; host_pd_n_pin = 0; step(3);
        host_rst_n_pin = 1; step(3);
        hw_standby = 1; step(1); hw_standby = 0;
        check(rd_data[6:5] == 2'b00, "R10 standby", rd_data[6:5], 0);
        host_pd_n_pin = 1; step(4);

        done = 1;
        summary();
    end

endmodule